// File: doc/BRIEF.md
# Management Indirect Register Bridge

This block is the management front end of a multi-device switch. On one side it takes single-cycle management register accesses, each carrying a PHY address, a 5-bit register number, a read or write strobe and 16-bit write data. On the other side it masters an internal register bus. The internal bus reaches a device address (5 bits) and a register address (5 bits) with a request/acknowledge handshake. A 5-bit strap input, `chip_addr`, picks one of two addressing schemes.

With the strap at zero the bridge is transparent. Every management access, whatever its PHY address, becomes one internal access that uses the PHY address as the device address. With a nonzero strap the bridge answers only its own address and shows two local registers. The data register is index 1. The command register is index 0; writing it packs a device and register address into one word and launches a single internal access. Software starts a write by loading the data register and then writing the command. It starts a read by writing the command, polling the busy flag and then reading the data register.

Every management access that the bridge accepts ends with a one-cycle `mg_done` pulse. Read data arrives with that pulse.

Top module: `mgmt_indirect_bridge`

## Requirements
- R1: With `chip_addr` = 0, every management access is accepted for any PHY address. It performs exactly one internal access with device = PHY address, register = management register and write data = management data. A read returns the internal value on `mg_rdata` with `mg_done`.
- R2: With `chip_addr` ≠ 0, an access whose PHY address differs from `chip_addr` produces no `mg_done`, no internal access and no change to the local registers.
- R3: Command word layout: bit 15 start/busy, bit 12 must be 1 (Clause 22 format), bits 11:10 opcode (2 = read, 1 = write), bits 9:5 device address, bits 4:0 register address. The command register is index 0 and the data register is index 1.
- R4: A launching command sets busy. Busy stays set until the internal acknowledge and reads as 0 from the cycle after it. Reading index 0 returns busy in bit 15 and the last accepted command's bits 14:0. Both local registers read 0 after reset.
- R5: An indirect write copies the current data register into the addressed internal register.
- R6: An indirect read leaves the internal value in the data register by the time busy reads 0.
- R7: Writes to the command or data register while busy is set are ignored.
- R8: A command with bit 15 clear, bit 12 clear, or opcode 0 or 3 is stored but makes no internal access, and busy stays 0.
- R9: The internal request stays high, with device, register, direction and data stable, until acknowledge. It drops on the cycle after acknowledge, and each launch makes exactly one access.
- R10: In indirect mode, reads of indices 2 to 31 return 0 and writes to them change nothing.
- R11: In indirect mode `mg_done` rises one cycle after the strobe. In direct mode it rises one cycle after the internal acknowledge, which is S+2 cycles after the strobe when the acknowledge is held off S cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chip_addr | input | 5 | Strapped chip address, 0 selects direct mode |
| mg_phy | input | 5 | Management PHY address of the access |
| mg_reg | input | 5 | Management register number |
| mg_wr | input | 1 | One-cycle write strobe |
| mg_rd | input | 1 | One-cycle read strobe |
| mg_wdata | input | 16 | Management write data |
| mg_done | output | 1 | One-cycle completion pulse |
| mg_rdata | output | 16 | Read data, valid with mg_done |
| ib_req | output | 1 | Internal bus request |
| ib_we | output | 1 | Internal bus direction, 1 = write |
| ib_dev | output | 5 | Internal device address |
| ib_reg | output | 5 | Internal register address |
| ib_wdata | output | 16 | Internal write data |
| ib_ack | input | 1 | Internal bus acknowledge |
| ib_rdata | input | 16 | Internal read data, valid with ib_ack |

## Verification
A corrupted busy flag shows up on the next poll of the command register, two cycles later at most. A stuck busy hangs the poll. A busy that clears early makes the data register read back the stale value instead of the internal word. A wrong latched address or direction turns up in the bench's count of internal accesses and in its memory model when the access completes. A broken mode decode shows as a missing `mg_done`, or as one that should not be there, within one cycle of the strobe.

// File: rtl/mib_pkg.sv
// Shared constants and types for the management indirect bridge.
// Assumes a 16-bit management data word and 5-bit address fields.
package mib_pkg;
    localparam int unsigned DW       = 16;
    localparam int unsigned AW       = 5;
    localparam int unsigned BIT_GO   = 15;
    localparam int unsigned BIT_C22  = 12;
    localparam int unsigned OP_LSB   = 10;
    localparam int unsigned DEV_LSB  = 5;
    localparam int unsigned REG_LSB  = 0;
    localparam int unsigned IDX_CMD  = 0;
    localparam int unsigned IDX_DATA = 1;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_WR   = 2'd1,
        OP_RD   = 2'd2,
        OP_RSV  = 2'd3
    } opcode_e;
endpackage

// File: rtl/mib_bus_master.sv
// Internal register bus master: latches one access on start and holds the
// request until acknowledge. Assumes start is only honoured while idle.
module mib_bus_master #(
    parameter int unsigned AW = 5,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          start_we,
    input  logic [AW-1:0] start_dev,
    input  logic [AW-1:0] start_reg,
    input  logic [DW-1:0] start_wdata,
    output logic          busy,
    output logic          fin,
    output logic          ib_req,
    output logic          ib_we,
    output logic [AW-1:0] ib_dev,
    output logic [AW-1:0] ib_reg,
    output logic [DW-1:0] ib_wdata,
    input  logic          ib_ack
);
    logic          req_q;
    logic          we_q;
    logic [AW-1:0] dev_q;
    logic [AW-1:0] reg_q;
    logic [DW-1:0] wd_q;

    // Request sequencer: capture on start, release on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            we_q  <= 1'b0;
            dev_q <= '0;
            reg_q <= '0;
            wd_q  <= '0;
        end else if (start && !req_q) begin
            req_q <= 1'b1;
            we_q  <= start_we;
            dev_q <= start_dev;
            reg_q <= start_reg;
            wd_q  <= start_wdata;
        end else if (req_q && ib_ack) begin
            req_q <= 1'b0;
        end
    end

    assign busy     = req_q;
    assign fin      = req_q & ib_ack;
    assign ib_req   = req_q;
    assign ib_we    = we_q;
    assign ib_dev   = dev_q;
    assign ib_reg   = reg_q;
    assign ib_wdata = wd_q;

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_req && !ib_ack) |=> (ib_req && $stable(ib_we) && $stable(ib_dev)
                                 && $stable(ib_reg) && $stable(ib_wdata)));
    assert_req_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ib_req && ib_ack) |=> !ib_req);
endmodule

// File: rtl/mib_cmd_file.sv
// Command and data registers used in indirect mode. Decodes command writes,
// launches at most one internal access and tracks busy. Assumes fin only
// arrives for an access this file launched.
module mib_cmd_file
    import mib_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          wr,
    input  logic [AW-1:0] reg_idx,
    input  logic [DW-1:0] wdata,
    input  logic          fin,
    input  logic [DW-1:0] rd_in,
    output logic          launch,
    output logic          launch_we,
    output logic [AW-1:0] launch_dev,
    output logic [AW-1:0] launch_reg,
    output logic [DW-1:0] launch_wdata,
    output logic [DW-1:0] rdata
);
    logic          busy_q;
    logic [DW-2:0] fld_q;
    logic [DW-1:0] data_q;
    opcode_e       new_op;
    opcode_e       cur_op;
    logic          cmd_hit;
    logic          data_hit;
    logic          cmd_ok;

    // Decode of the incoming write and of the stored command.
    always_comb begin
        new_op   = opcode_e'(wdata[OP_LSB +: 2]);
        cur_op   = opcode_e'(fld_q[OP_LSB +: 2]);
        cmd_hit  = sel && wr && (reg_idx == AW'(IDX_CMD)) && !busy_q;
        data_hit = sel && wr && (reg_idx == AW'(IDX_DATA)) && !busy_q;
        cmd_ok   = wdata[BIT_GO] && wdata[BIT_C22] && (new_op == OP_RD || new_op == OP_WR);
    end

    assign launch       = cmd_hit && cmd_ok;
    assign launch_we    = (new_op == OP_WR);
    assign launch_dev   = wdata[DEV_LSB +: AW];
    assign launch_reg   = wdata[REG_LSB +: AW];
    assign launch_wdata = data_q;

    // Stored command fields, updated by every accepted command write.
    always_ff @(posedge clk) begin
        if (!rst_n)       fld_q <= '0;
        else if (cmd_hit) fld_q <= wdata[DW-2:0];
    end

    // Busy flag: set by a launch, cleared at the acknowledge edge.
    always_ff @(posedge clk) begin
        if (!rst_n)      busy_q <= 1'b0;
        else if (launch) busy_q <= 1'b1;
        else if (fin)    busy_q <= 1'b0;
    end

    // Data register: software load, or read result on completion.
    always_ff @(posedge clk) begin
        if (!rst_n)                             data_q <= '0;
        else if (data_hit)                      data_q <= wdata;
        else if (fin && busy_q && cur_op == OP_RD) data_q <= rd_in;
    end

    // Read mux for the local register indices.
    always_comb begin
        if (reg_idx == AW'(IDX_CMD))       rdata = {busy_q, fld_q};
        else if (reg_idx == AW'(IDX_DATA)) rdata = data_q;
        else                               rdata = '0;
    end

    assert_busy_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !fin) |=> busy_q);
    assert_busy_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && fin) |=> !busy_q);
    assert_ignore_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && sel && wr && !fin) |=> ($stable(fld_q) && $stable(data_q)));
    assert_invalid_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && sel && wr && reg_idx == AW'(IDX_CMD) && !cmd_ok) |=> !busy_q);
endmodule

// File: rtl/mgmt_indirect_bridge.sv
// Top of the management bridge. Selects direct or indirect addressing from
// the strap, shares one internal bus master between both paths and returns
// a registered completion pulse. Assumes chip_addr is static while out of reset.
module mgmt_indirect_bridge
    import mib_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] chip_addr,
    input  logic [AW-1:0] mg_phy,
    input  logic [AW-1:0] mg_reg,
    input  logic          mg_wr,
    input  logic          mg_rd,
    input  logic [DW-1:0] mg_wdata,
    output logic          mg_done,
    output logic [DW-1:0] mg_rdata,
    output logic          ib_req,
    output logic          ib_we,
    output logic [AW-1:0] ib_dev,
    output logic [AW-1:0] ib_reg,
    output logic [DW-1:0] ib_wdata,
    input  logic          ib_ack,
    input  logic [DW-1:0] ib_rdata
);
    logic          direct;
    logic          sel_ind;
    logic          strobe;
    logic          bm_busy;
    logic          bm_fin;
    logic          d_start;
    logic          f_launch;
    logic          f_we;
    logic [AW-1:0] f_dev;
    logic [AW-1:0] f_reg;
    logic [DW-1:0] f_wdata;
    logic [DW-1:0] f_rdata;
    logic          s_start;
    logic          s_we;
    logic [AW-1:0] s_dev;
    logic [AW-1:0] s_reg;
    logic [DW-1:0] s_wdata;
    logic          own_dir_q;
    logic          dir_we_q;

    // Mode decode and start selection between the two paths.
    always_comb begin
        direct  = (chip_addr == '0);
        strobe  = mg_wr || mg_rd;
        sel_ind = !direct && (mg_phy == chip_addr);
        d_start = direct && strobe && !bm_busy;
        s_start = d_start || f_launch;
        s_we    = direct ? mg_wr    : f_we;
        s_dev   = direct ? mg_phy   : f_dev;
        s_reg   = direct ? mg_reg   : f_reg;
        s_wdata = direct ? mg_wdata : f_wdata;
    end

    mib_cmd_file u_cmd (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel          (sel_ind),
        .wr           (mg_wr),
        .reg_idx      (mg_reg),
        .wdata        (mg_wdata),
        .fin          (bm_fin),
        .rd_in        (ib_rdata),
        .launch       (f_launch),
        .launch_we    (f_we),
        .launch_dev   (f_dev),
        .launch_reg   (f_reg),
        .launch_wdata (f_wdata),
        .rdata        (f_rdata)
    );

    mib_bus_master #(.AW(AW), .DW(DW)) u_bus (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (s_start),
        .start_we    (s_we),
        .start_dev   (s_dev),
        .start_reg   (s_reg),
        .start_wdata (s_wdata),
        .busy        (bm_busy),
        .fin         (bm_fin),
        .ib_req      (ib_req),
        .ib_we       (ib_we),
        .ib_dev      (ib_dev),
        .ib_reg      (ib_reg),
        .ib_wdata    (ib_wdata),
        .ib_ack      (ib_ack)
    );

    // Remember which path owns the running internal access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_dir_q <= 1'b0;
            dir_we_q  <= 1'b0;
        end else if (s_start && !bm_busy) begin
            own_dir_q <= d_start;
            dir_we_q  <= mg_wr;
        end
    end

    // Registered completion pulse and read data for the management side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mg_done  <= 1'b0;
            mg_rdata <= '0;
        end else if (bm_fin && own_dir_q) begin
            mg_done  <= 1'b1;
            mg_rdata <= dir_we_q ? '0 : ib_rdata;
        end else if (sel_ind && strobe) begin
            mg_done  <= 1'b1;
            mg_rdata <= mg_wr ? '0 : f_rdata;
        end else begin
            mg_done  <= 1'b0;
        end
    end

    assert_foreign_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!direct && strobe && mg_phy != chip_addr) |=> !mg_done);
    assert_local_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_ind && strobe) |=> mg_done);
endmodule

// File: tb/mgmt_indirect_bridge_test.sv
`timescale 1ns/1ps
module mgmt_indirect_bridge_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  chip_addr = '0;
    logic [4:0]  mg_phy = '0;
    logic [4:0]  mg_reg = '0;
    logic        mg_wr = 1'b0;
    logic        mg_rd = 1'b0;
    logic [15:0] mg_wdata = '0;
    logic        mg_done;
    logic [15:0] mg_rdata;
    logic        ib_req, ib_we;
    logic [4:0]  ib_dev, ib_reg;
    logic [15:0] ib_wdata;
    logic        ib_ack = 1'b0;
    logic [15:0] ib_rdata = '0;

    always #4 clk = ~clk;

    mgmt_indirect_bridge uut (
        .clk(clk), .rst_n(rst_n), .chip_addr(chip_addr), .mg_phy(mg_phy),
        .mg_reg(mg_reg), .mg_wr(mg_wr), .mg_rd(mg_rd), .mg_wdata(mg_wdata),
        .mg_done(mg_done), .mg_rdata(mg_rdata), .ib_req(ib_req), .ib_we(ib_we),
        .ib_dev(ib_dev), .ib_reg(ib_reg), .ib_wdata(ib_wdata), .ib_ack(ib_ack),
        .ib_rdata(ib_rdata)
    );

    int n_tests = 0, n_fail = 0, cyc = 0, pops = 0, done_cyc = 0, last_lat = 0;
    int acc_cnt = 0, stall_fix = -1, wl = 0;
    bit pend = 0, finished = 0;
    logic [9:0]  last_addr = '0;
    logic [15:0] got_val = '0;
    logic [15:0] mem [0:1023];
    logic [15:0] exp_q[$];
    bit          cmp_q[$];
    string       tag_q[$];
    string       cur_tag = "";

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // Internal bus responder with a programmable or random acknowledge stall.
    always @(negedge clk) begin
        if (!rst_n) begin
            ib_ack = 1'b0; pend = 1'b0;
        end else if (ib_ack) begin
            ib_ack = 1'b0; pend = 1'b0;
        end else if (ib_req) begin
            if (!pend) begin
                pend = 1'b1;
                wl = (stall_fix < 0) ? int'($urandom_range(0, 4)) : stall_fix;
            end
            if (wl == 0) begin
                ib_ack = 1'b1;
                ib_rdata = mem[{ib_dev, ib_reg}];
                if (ib_we) mem[{ib_dev, ib_reg}] = ib_wdata;
                acc_cnt++;
                last_addr = {ib_dev, ib_reg};
            end else begin
                wl--;
            end
        end
    end

    // Scoreboard monitor: pops an expected item on every completion.
    always @(negedge clk) begin
        if (rst_n && mg_done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, cur_tag, "unexpected mg_done", {16'h0, mg_rdata}, 32'h0);
            end else begin
                logic [15:0] e;
                bit c;
                string t;
                e = exp_q.pop_front(); c = cmp_q.pop_front(); t = tag_q.pop_front();
                got_val = mg_rdata; done_cyc = cyc; pops++;
                if (c) chk(mg_rdata == e, t, "mg_rdata", {16'h0, mg_rdata}, {16'h0, e});
            end
        end
    end

    // Driver: one management access, with the expected result queued.
    task automatic acc(input logic [4:0] phy, input logic [4:0] r, input bit w,
                       input logic [15:0] wd, input bit exp_done, input bit cmp,
                       input logic [15:0] ev, input string tag);
        int p0, c0, i;
        @(negedge clk);
        mg_phy = phy; mg_reg = r; mg_wr = w; mg_rd = !w; mg_wdata = wd;
        cur_tag = tag; c0 = cyc; p0 = pops;
        if (exp_done) begin
            exp_q.push_back(ev); cmp_q.push_back(cmp); tag_q.push_back(tag);
        end
        @(negedge clk);
        mg_wr = 1'b0; mg_rd = 1'b0;
        #1;
        if (exp_done) begin
            i = 0;
            while (pops == p0 && i < 80) begin
                @(negedge clk); #1; i++;
            end
            if (pops == p0) begin
                chk(1'b0, tag, "no mg_done", 0, 1);
                void'(exp_q.pop_front()); void'(cmp_q.pop_front()); void'(tag_q.pop_front());
            end else begin
                last_lat = done_cyc - c0;
            end
        end else begin
            repeat (8) @(negedge clk);
        end
    endtask

    task automatic wait_idle(input string tag);
        for (int k = 0; k < 100; k++) begin
            acc(chip_addr, 5'd0, 1'b0, 16'h0, 1'b1, 1'b0, 16'h0, tag);
            if (!got_val[15]) break;
        end
        chk(!got_val[15], tag, "busy never cleared", {16'h0, got_val}, 32'h0);
    endtask

    task automatic do_reset(input logic [4:0] strap);
        @(negedge clk);
        rst_n = 1'b0; chip_addr = strap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int a0;
        for (int i = 0; i < 1024; i++) mem[i] = 16'(i * 257) ^ 16'h5A5A;
        mem[17*32+31] = 16'hBEEF;
        mem[13*32+18] = 16'h7E11;
        mem[31*32+31] = 16'hC0DE;

        // Direct mode (strap 0).
        do_reset(5'd0);
        #1;
        chk(mg_done == 1'b0 && ib_req == 1'b0, "R9", "reset outputs", {mg_done, ib_req}, 0);
        a0 = acc_cnt;
        acc(5'd3, 5'd7, 1'b1, 16'h1234, 1'b1, 1'b0, 16'h0, "R1");
        chk(mem[3*32+7] == 16'h1234, "R1", "direct write stored", mem[3*32+7], 16'h1234);
        chk(acc_cnt == a0 + 1, "R9", "one access per direct write", acc_cnt, a0 + 1);
        acc(5'd17, 5'd31, 1'b0, 16'h0, 1'b1, 1'b1, 16'hBEEF, "R1");
        chk(last_addr == {5'd17, 5'd31}, "R1", "direct address", last_addr, {5'd17, 5'd31});
        stall_fix = 3;
        acc(5'd0, 5'd0, 1'b0, 16'h0, 1'b1, 1'b1, mem[0], "R11");
        chk(last_lat == 5, "R11", "direct latency", last_lat, 5);
        stall_fix = -1;

        // Indirect mode (strap 5).
        do_reset(5'd5);
        acc(5'd5, 5'd0, 1'b0, 16'h0, 1'b1, 1'b1, 16'h0000, "R4");
        acc(5'd5, 5'd1, 1'b0, 16'h0, 1'b1, 1'b1, 16'h0000, "R4");
        chk(last_lat == 1, "R11", "indirect latency", last_lat, 1);

        // R5: indirect write with random stalls.
        a0 = acc_cnt;
        acc(5'd5, 5'd1, 1'b1, 16'hA5C3, 1'b1, 1'b0, 16'h0, "R5");
        acc(5'd5, 5'd0, 1'b1, 16'h9524, 1'b1, 1'b0, 16'h0, "R5");
        wait_idle("R4");
        chk(mem[9*32+4] == 16'hA5C3, "R5", "indirect write stored", mem[9*32+4], 16'hA5C3);
        chk(acc_cnt == a0 + 1, "R9", "one access per launch", acc_cnt, a0 + 1);
        acc(5'd5, 5'd0, 1'b0, 16'h0, 1'b1, 1'b1, 16'h1524, "R4");

        // R3/R4/R6/R7: long-stalled indirect read with writes while busy.
        stall_fix = 20;
        a0 = acc_cnt;
        acc(5'd5, 5'd0, 1'b1, 16'h99B2, 1'b1, 1'b0, 16'h0, "R3");
        acc(5'd5, 5'd0, 1'b0, 16'h0, 1'b1, 1'b1, 16'h99B2, "R4");
        acc(5'd5, 5'd0, 1'b0, 16'h0, 1'b1, 1'b1, 16'h99B2, "R4");
        acc(5'd5, 5'd0, 1'b1, 16'h9524, 1'b1, 1'b0, 16'h0, "R7");
        acc(5'd5, 5'd1, 1'b1, 16'h1111, 1'b1, 1'b0, 16'h0, "R7");
        wait_idle("R4");
        acc(5'd5, 5'd1, 1'b0, 16'h0, 1'b1, 1'b1, 16'h7E11, "R6");
        acc(5'd5, 5'd0, 1'b0, 16'h0, 1'b1, 1'b1, 16'h19B2, "R7");
        chk(acc_cnt == a0 + 1, "R7", "busy command ignored", acc_cnt, a0 + 1);
        stall_fix = -1;

        // R3 boundary: highest device and register.
        acc(5'd5, 5'd0, 1'b1, 16'h9BFF, 1'b1, 1'b0, 16'h0, "R3");
        wait_idle("R4");
        acc(5'd5, 5'd1, 1'b0, 16'h0, 1'b1, 1'b1, 16'hC0DE, "R3");
        chk(last_addr == 10'h3FF, "R3", "max address fields", last_addr, 10'h3FF);

        // R8: commands that must not launch.
        a0 = acc_cnt;
        acc(5'd5, 5'd0, 1'b1, 16'h9C21, 1'b1, 1'b0, 16'h0, "R8");
        acc(5'd5, 5'd0, 1'b0, 16'h0, 1'b1, 1'b1, 16'h1C21, "R8");
        acc(5'd5, 5'd0, 1'b1, 16'h8821, 1'b1, 1'b0, 16'h0, "R8");
        acc(5'd5, 5'd0, 1'b0, 16'h0, 1'b1, 1'b1, 16'h0821, "R8");
        acc(5'd5, 5'd0, 1'b1, 16'h1821, 1'b1, 1'b0, 16'h0, "R8");
        acc(5'd5, 5'd0, 1'b0, 16'h0, 1'b1, 1'b1, 16'h1821, "R8");
        chk(acc_cnt == a0, "R8", "no internal access", acc_cnt, a0);

        // R2: other PHY addresses are not answered.
        acc(5'd6, 5'd0, 1'b1, 16'h9524, 1'b0, 1'b0, 16'h0, "R2");
        acc(5'd0, 5'd1, 1'b1, 16'hDEAD, 1'b0, 1'b0, 16'h0, "R2");
        acc(5'd31, 5'd0, 1'b0, 16'h0, 1'b0, 1'b0, 16'h0, "R2");
        acc(5'd5, 5'd0, 1'b0, 16'h0, 1'b1, 1'b1, 16'h1821, "R2");
        acc(5'd5, 5'd1, 1'b0, 16'h0, 1'b1, 1'b1, 16'hC0DE, "R2");
        chk(acc_cnt == a0, "R2", "no internal access", acc_cnt, a0);

        // R10: unused indices.
        acc(5'd5, 5'd7, 1'b0, 16'h0, 1'b1, 1'b1, 16'h0000, "R10");
        acc(5'd5, 5'd3, 1'b1, 16'hFFFF, 1'b1, 1'b0, 16'h0, "R10");
        acc(5'd5, 5'd31, 1'b0, 16'h0, 1'b1, 1'b1, 16'h0000, "R10");
        acc(5'd5, 5'd0, 1'b0, 16'h0, 1'b1, 1'b1, 16'h1821, "R10");
        acc(5'd5, 5'd1, 1'b0, 16'h0, 1'b1, 1'b1, 16'hC0DE, "R10");
        chk(acc_cnt == a0, "R10", "no internal access", acc_cnt, a0);

        repeat (4) @(negedge clk);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule